// File: doc/BRIEF.md
# Speculative and Committed Register Map Table

This block translates the 32 logical registers of an out-of-order core into physical register indices, and it keeps two copies of that translation. The speculative copy serves the rename stage. Every rename lane reads, in the same cycle, the physical index of each of its source operands. It also reads the index that its destination currently maps to, so that the old mapping can travel down the pipeline and later be freed or restored. New destination mappings chosen by rename are written back through per-lane write ports.

The committed copy changes only when an instruction retires with a destination. Recovery can happen in two ways. In a walk, the retire logic replays instructions youngest-first, and the same speculative write ports put each old mapping back. A flush instead copies the whole committed copy into the speculative copy in one cycle. A redirect cancels the rename writes offered in that cycle. All 32 committed entries are brought out for debug.

Top module: `rename_map_table`

## Requirements
- R1: After reset, entry k of both the speculative and the committed map holds physical index k, for every k from 0 to 31.
- R2: Rename lane n has SRC_N+1 combinational read ports of the speculative map, numbered p = n*(SRC_N+1)+k. The address of port p is rd_addr[p*LW +: LW] and its data is rd_data[p*PW +: PW]. Ports k < SRC_N serve the sources and port k = SRC_N serves the destination. Every port returns the map as it stood before the writes of the current cycle.
- R3: When ren_wen[n] is set (n < REN_W), the speculative entry ren_ldest of lane n takes ren_pdest of lane n at the next edge. The committed map is not changed by this write.
- R4: While walk is high, every commit lane i (0 to CMT_W-1) whose cmt_valid[i] and cmt_has_dest[i] are both set writes cmt_old_pdest of lane i into the speculative entry cmt_ldest of lane i. A lane with cmt_has_dest clear writes nothing. Lanes at or above REN_W carry only these walk writes.
- R5: In a lane below REN_W that offers both a rename write and a walk write in the same cycle, the rename write is the one applied.
- R6: When several lanes write the same entry of either map in one cycle, the write from the highest-numbered lane is the one kept.
- R7: The committed entry cmt_ldest of lane i takes cmt_pdest of lane i only when walk is low and cmt_valid[i] and cmt_has_dest[i] are both set. Commits never change the speculative map, and the committed map holds its value in any walk cycle.
- R8: While redirect is high, rename writes are discarded, while walk writes are still applied.
- R9: A flush loads the speculative map with the committed map as it stood before the current cycle's commits, overriding every speculative write of that cycle. Commits in the same cycle still update the committed map.
- R10: arch_map[k*PW +: PW] shows committed entry k, for all 32 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Copy the committed map into the speculative map |
| redirect | input | 1 | Discard this cycle's rename writes |
| walk | input | 1 | Commit lanes replay old mappings into the speculative map |
| rd_addr | input | REN_W*(SRC_N+1)*LW | Logical address of each read port |
| rd_data | output | REN_W*(SRC_N+1)*PW | Physical index returned by each read port |
| ren_wen | input | REN_W | Rename write enable per lane |
| ren_ldest | input | REN_W*LW | Logical destination per rename lane |
| ren_pdest | input | REN_W*PW | New physical destination per rename lane |
| cmt_valid | input | CMT_W | Commit or walk lane valid |
| cmt_has_dest | input | CMT_W | Lane's instruction writes a destination |
| cmt_ldest | input | CMT_W*LW | Logical destination per commit lane |
| cmt_pdest | input | CMT_W*PW | Physical destination per commit lane |
| cmt_old_pdest | input | CMT_W*PW | Previous physical destination per commit lane |
| arch_map | output | NLOG*PW | Committed map, entry k in slice k |

## Verification
The hardest state to reach is a speculative map that really differs from the committed map, because only then can a flush be seen to copy the committed map rather than keep the old speculative one. The bench builds up that gap on purpose. Earlier scenarios leave rename and walk mappings in the speculative copy and unrelated commits in the committed copy. The flush is then issued together with a rename write and a commit. This shows in one cycle that the flush overrides the rename write and takes the committed contents from before the commit. Collisions within a lane and between lanes are driven as single cycles that hold several competing writes to one entry.

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NLOG  = 32,
  parameter int PW    = 7,
  parameter int REN_W = 4,
  parameter int CMT_W = 6,
  parameter int SRC_N = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic                              redirect,
  input  logic                              walk,
  input  logic [REN_W*(SRC_N+1)*$clog2(NLOG)-1:0] rd_addr,
  output logic [REN_W*(SRC_N+1)*PW-1:0]     rd_data,
  input  logic [REN_W-1:0]                  ren_wen,
  input  logic [REN_W*$clog2(NLOG)-1:0]     ren_ldest,
  input  logic [REN_W*PW-1:0]               ren_pdest,
  input  logic [CMT_W-1:0]                  cmt_valid,
  input  logic [CMT_W-1:0]                  cmt_has_dest,
  input  logic [CMT_W*$clog2(NLOG)-1:0]     cmt_ldest,
  input  logic [CMT_W*PW-1:0]               cmt_pdest,
  input  logic [CMT_W*PW-1:0]               cmt_old_pdest,
  output logic [NLOG*PW-1:0]                arch_map
);
  localparam int LW  = $clog2(NLOG);
  localparam int NRD = REN_W * (SRC_N + 1);

  logic [NLOG-1:0][PW-1:0] spec, spec_nxt, arch, arch_nxt;
  logic [CMT_W-1:0]          sw_en;
  logic [CMT_W-1:0][LW-1:0]  sw_addr;
  logic [CMT_W-1:0][PW-1:0]  sw_data;
  logic [CMT_W-1:0]          walk_w;

  genvar g;
  generate
    for (g = 0; g < CMT_W; g++) begin : g_lane
      assign walk_w[g] = walk && cmt_valid[g] && cmt_has_dest[g];
      if (g < REN_W) begin : g_ren
        wire ren_act = ren_wen[g] && !redirect;
        assign sw_en[g]   = ren_act || walk_w[g];
        assign sw_addr[g] = ren_act ? ren_ldest[g*LW +: LW] : cmt_ldest[g*LW +: LW];
        assign sw_data[g] = ren_act ? ren_pdest[g*PW +: PW] : cmt_old_pdest[g*PW +: PW];
      end else begin : g_walk_only
        assign sw_en[g]   = walk_w[g];
        assign sw_addr[g] = cmt_ldest[g*LW +: LW];
        assign sw_data[g] = cmt_old_pdest[g*PW +: PW];
      end
    end
    for (g = 0; g < NRD; g++) begin : g_rd
      assign rd_data[g*PW +: PW] = spec[rd_addr[g*LW +: LW]];
    end
  endgenerate

  always_comb begin
    spec_nxt = spec;
    arch_nxt = arch;
    for (int i = 0; i < CMT_W; i++) begin
      if (sw_en[i]) spec_nxt[sw_addr[i]] = sw_data[i];
      if (!walk && cmt_valid[i] && cmt_has_dest[i])
        arch_nxt[cmt_ldest[i*LW +: LW]] = cmt_pdest[i*PW +: PW];
    end
    if (flush) spec_nxt = arch;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NLOG; k++) begin
        spec[k] <= PW'(k);
        arch[k] <= PW'(k);
      end
    end else begin
      spec <= spec_nxt;
      arch <= arch_nxt;
    end
  end

  assign arch_map = arch;

  // R9
  flush_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> spec == $past(arch));

  // R7
  arch_walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(walk) |-> arch == $past(arch));

  // R7
  arch_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmt_valid == '0) |-> arch == $past(arch));

  // R8
  spec_redirect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(redirect && !walk && !flush) |-> spec == $past(spec));
endmodule

// File: tb/rename_map_table_test.sv
module rename_map_table_test;
  localparam int CLK_P = 10;
  localparam int NLOG = 32, PW = 7, REN_W = 4, CMT_W = 6, SRC_N = 3;
  localparam int LW = 5, RP = SRC_N + 1, NRD = REN_W * RP;

  logic clk = 0, rst_n = 0, flush = 0, redirect = 0, walk = 0;
  logic [NRD*LW-1:0] rd_addr = '0;
  logic [NRD*PW-1:0] rd_data;
  logic [REN_W-1:0] ren_wen = '0;
  logic [REN_W*LW-1:0] ren_ldest = '0;
  logic [REN_W*PW-1:0] ren_pdest = '0;
  logic [CMT_W-1:0] cmt_valid = '0, cmt_has_dest = '0;
  logic [CMT_W*LW-1:0] cmt_ldest = '0;
  logic [CMT_W*PW-1:0] cmt_pdest = '0, cmt_old_pdest = '0;
  logic [NLOG*PW-1:0] arch_map;
  int n_chk = 0, n_bad = 0;

  rename_map_table #(.NLOG(NLOG), .PW(PW), .REN_W(REN_W), .CMT_W(CMT_W), .SRC_N(SRC_N)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .redirect(redirect), .walk(walk),
    .rd_addr(rd_addr), .rd_data(rd_data), .ren_wen(ren_wen), .ren_ldest(ren_ldest),
    .ren_pdest(ren_pdest), .cmt_valid(cmt_valid), .cmt_has_dest(cmt_has_dest),
    .cmt_ldest(cmt_ldest), .cmt_pdest(cmt_pdest), .cmt_old_pdest(cmt_old_pdest),
    .arch_map(arch_map));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(int lane, int k, int la, output int v);
    int p = lane * RP + k;
    rd_addr[p*LW +: LW] = LW'(la);
    #1;
    v = int'(rd_data[p*PW +: PW]);
  endtask

  task automatic spec_chk(string req, int la, int exp);
    int v;
    rd(0, 0, la, v);
    chk(req, v, exp);
  endtask

  task automatic arch_chk(string req, int la, int exp);
    chk(req, int'(arch_map[la*PW +: PW]), exp);
  endtask

  task automatic idle();
    flush = 0; redirect = 0; walk = 0; ren_wen = '0;
    cmt_valid = '0; cmt_has_dest = '0;
  endtask

  task automatic ren(int lane, int la, int pd);
    ren_wen[lane] = 1;
    ren_ldest[lane*LW +: LW] = LW'(la);
    ren_pdest[lane*PW +: PW] = PW'(pd);
  endtask

  task automatic cmt(int lane, bit hd, int la, int pd, int opd);
    cmt_valid[lane] = 1;
    cmt_has_dest[lane] = hd;
    cmt_ldest[lane*LW +: LW] = LW'(la);
    cmt_pdest[lane*PW +: PW] = PW'(pd);
    cmt_old_pdest[lane*PW +: PW] = PW'(opd);
  endtask

  task automatic tick();
    @(posedge clk); #1; idle();
  endtask

  task automatic t_reset();
    int bad = 0;
    for (int k = 0; k < NLOG; k++) begin
      int v;
      rd(k % REN_W, k % RP, k, v);
      if (v != k) bad++;
      if (int'(arch_map[k*PW +: PW]) != k) bad++;
    end
    chk("R1 identity maps after reset", bad, 0);
    chk("R10 debug slice 31", int'(arch_map[31*PW +: PW]), 31);
  endtask

  task automatic t_rename();
    int v;
    @(negedge clk);
    ren(1, 3, 40); ren(2, 7, 41);
    rd(0, 0, 3, v);
    chk("R2 read before same-cycle write", v, 3);
    tick();
    rd(3, SRC_N, 7, v);
    chk("R2 destination port old mapping", v, 41);
    spec_chk("R3 rename write lane1", 3, 40);
    arch_chk("R3 committed map untouched", 3, 3);
  endtask

  task automatic t_collide();
    @(negedge clk);
    ren(0, 5, 50); ren(3, 5, 53);
    tick();
    spec_chk("R6 rename collision highest lane", 5, 53);
    @(negedge clk);
    walk = 1; cmt(1, 1, 6, 0, 60); cmt(5, 1, 6, 0, 65);
    tick();
    spec_chk("R6 walk collision highest lane", 6, 65);
  endtask

  task automatic t_walk();
    @(negedge clk);
    walk = 1;
    ren(1, 8, 70); cmt(1, 1, 8, 33, 71);
    cmt(2, 1, 9, 34, 72);
    cmt(3, 0, 10, 35, 73);
    cmt(5, 1, 11, 36, 75);
    tick();
    spec_chk("R5 rename beats walk in lane", 8, 70);
    spec_chk("R4 walk restores old index", 9, 72);
    spec_chk("R4 no destination no write", 10, 10);
    spec_chk("R4 upper walk-only lane", 11, 75);
    arch_chk("R7 committed map held during walk", 9, 9);
  endtask

  task automatic t_commit();
    @(negedge clk);
    cmt(0, 1, 12, 80, 1); cmt(4, 1, 13, 81, 2); cmt(2, 0, 14, 82, 3);
    cmt(1, 1, 15, 90, 4); cmt(3, 1, 15, 91, 5);
    tick();
    arch_chk("R7 commit lane0", 12, 80);
    arch_chk("R7 commit lane4", 13, 81);
    arch_chk("R7 no destination", 14, 14);
    arch_chk("R6 committed collision", 15, 91);
    spec_chk("R7 speculative map untouched", 12, 12);
  endtask

  task automatic t_redirect();
    @(negedge clk);
    redirect = 1; ren(0, 16, 99); walk = 1; cmt(4, 1, 17, 0, 77);
    tick();
    spec_chk("R8 rename write discarded", 16, 16);
    spec_chk("R8 walk write kept", 17, 77);
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1; ren(0, 20, 100); cmt(0, 1, 21, 101, 6);
    tick();
    spec_chk("R9 speculative restored", 3, 3);
    spec_chk("R9 committed value copied", 12, 80);
    spec_chk("R9 committed collision copied", 15, 91);
    spec_chk("R9 rename write overridden", 20, 20);
    spec_chk("R9 copy precedes commit", 21, 21);
    arch_chk("R9 commit still applied", 21, 101);
    arch_chk("R10 debug slice 13", 13, 81);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_rename();
    t_collide();
    t_walk();
    t_commit();
    t_redirect();
    t_flush();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule